// File: doc/BRIEF.md
# MDIO Management Master

This block acts as a host-programmed master on a two-wire PHY management link. Software programs a divider and a preamble option in a mode register. It places a PHY address and a register address in an address register, and for writes places the value in a write-data register. It then sets one bit in the command register. The block sends a clause-22 management frame on the serial data line and produces the management clock from the system clock. For reads it captures the PHY's reply into a read-data register.

A status register reports three flags: a busy flag, which software polls until the transaction ends, a link-fail flag and an invalid flag. A scan command repeats the same read back to back. After each scan read, the read-data register is refreshed and the link-fail flag is updated from bit 2 of the returned word. After a command finishes, software must write zero to the command register before the block accepts another command.

The serial data line is bidirectional and is split into an output, an output enable and an input. The output changes only after a falling management-clock transition, and the input is sampled at the rising transition.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_o and mdio_oe are low, and the mode, command, read-data and status registers read as zero.
- R2: mdc stays high for H system clocks and low for H system clocks, where H is mode[7:1] (mode[0] is ignored, so the divider is always even). A value of zero is treated as H = 1. mdc is held low while no frame is in progress.
- R3: A write command (command bit 2) sends, MSB first, 32 ones, then 01, the opcode 01, the PHY address (addr[4:0]), the register address (addr[12:8]), the turnaround 10 and the value in wdata[15:0]. mdio_oe is high for the whole frame.
- R4: A read command (command bit 1) sends the opcode 10. It releases mdio_oe for the two turnaround bits and the 16 data bits. The 16 bits sampled from mdio_i, MSB first, appear in read-data[15:0].
- R5: When mode bit 8 is set, the 32-bit preamble is left out and the frame starts directly with the 01 start bits.
- R6: Status bit 1 (busy) goes high one clock after the command register is written with a command. It stays high until the frame has finished, and each command produces exactly one frame.
- R7: A command is not repeated while the command register still holds it after completion. A new command is accepted only after the command register has been written to zero.
- R8: If the read and write bits are both set, a read is performed.
- R9: Command bit 0 (scan) takes precedence over read and write. Reads are repeated back to back while the bit stays set. Each read updates read-data, and status bit 0 (link fail) becomes the inverse of bit 2 of the returned word. Status bit 2 (invalid) is high from the start of the scan until its first read completes. Once the scan bit is cleared, busy drops after the read in flight.
- R10: mdio_o and mdio_oe change only at falling mdc transitions (or when a frame is loaded while mdc is low). They are stable at every rising mdc transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write register index: 0 mode, 1 command, 2 address, 3 write data |
| reg_wdata | input | 32 | Register write value |
| reg_raddr | input | 3 | Read register index: 0 to 3 as for writes, 4 read data, 5 status |
| reg_rdata | output | 32 | Registered read value, valid one clock after reg_raddr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data output |
| mdio_oe | output | 1 | Output enable for the serial data line |
| mdio_i | input | 1 | Serial data input from the line |

## Verification
A command write takes effect at the edge it is accepted on. Busy is set one clock later, and the first frame bit drives mdio_o one clock after that. The bench reads status only after these edges, through the registered read port, which adds one clock of latency that each read task waits out. Frame bits are captured by a PHY model at each rising mdc, which is the edge the design itself samples at. The model drives its reply bits only at falling mdc, so a reply bit is in place well before the design samples it. A frame counts as complete at the falling mdc after its last rising edge. Read-data and the status flags are refreshed one clock later, so the bench waits a few clocks after a frame ends before reading them back.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] RI_MODE = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_CMD  = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_ADDR = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_WDAT = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_RDAT = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_STAT = 3'd5;

  localparam int PRE_BITS   = 32;
  localparam int BODY_BITS  = 32;
  localparam int DATA_BITS  = 16;
  localparam int FIELD_BITS = 5;
  // turnaround plus data: the bits released by the master on a read
  localparam int TAIL_RELEASED = DATA_BITS + 2;

  // command register bit positions
  localparam int CB_SCAN  = 0;
  localparam int CB_READ  = 1;
  localparam int CB_WRITE = 2;

  typedef struct packed {
    logic                  rd;
    logic                  nopre;
    logic [FIELD_BITS-1:0] phy;
    logic [FIELD_BITS-1:0] rga;
    logic [DATA_BITS-1:0]  wd;
  } mdio_req_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-2:0] half,
  output logic             mdc,
  output logic             rise_now,
  output logic             fall_now
);
  localparam int HW = DIV_W - 1;

  logic [HW-1:0] cnt_q;
  logic          mdc_q;
  logic [HW-1:0] half_eff;
  logic          term;

  always_comb begin
    half_eff = (half == '0) ? HW'(1) : half;
    term     = (cnt_q == half_eff - 1'b1);
    // strobes announce the transition that the next edge performs
    rise_now = en & term & ~mdc_q;
    fall_now = en & term & mdc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  mdio_req_t            req,
  input  logic                 rise_now,
  input  logic                 fall_now,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 done,
  output logic [DATA_BITS-1:0] rx_word,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam int FRAME_W = PRE_BITS + BODY_BITS;
  localparam int POS_W   = $clog2(FRAME_W);

  logic [BODY_BITS-1:0] body;
  logic [FRAME_W-1:0]   load;
  logic [POS_W-1:0]     pos_load;
  logic [FRAME_W-1:0]   sh_q;
  logic [POS_W-1:0]     pos_q;
  logic [POS_W-1:0]     pos_nxt;
  logic                 rd_q;
  logic [DATA_BITS-1:0] rxsh_q;

  always_comb begin
    body = {2'b01,
            (req.rd ? 2'b10 : 2'b01),
            req.phy,
            req.rga,
            (req.rd ? 2'b00 : 2'b10),
            (req.rd ? {DATA_BITS{1'b0}} : req.wd)};
    if (req.nopre) begin
      load     = {body, {PRE_BITS{1'b0}}};
      pos_load = POS_W'(BODY_BITS - 1);
    end else begin
      load     = {{PRE_BITS{1'b1}}, body};
      pos_load = POS_W'(FRAME_W - 1);
    end
    pos_nxt = pos_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      done    <= 1'b0;
      sh_q    <= '0;
      pos_q   <= '0;
      rd_q    <= 1'b0;
      rxsh_q  <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        sh_q    <= load;
        pos_q   <= pos_load;
        rd_q    <= req.rd;
        rxsh_q  <= '0;
        mdio_o  <= load[FRAME_W-1];
        mdio_oe <= 1'b1;
      end else if (active) begin
        if (rise_now && rd_q && (pos_q < POS_W'(DATA_BITS))) begin
          rxsh_q <= {rxsh_q[DATA_BITS-2:0], mdio_i};
        end
        if (fall_now) begin
          if (pos_q == '0) begin
            active  <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            pos_q   <= pos_nxt;
            sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
            mdio_o  <= sh_q[FRAME_W-2];
            mdio_oe <= !rd_q || (pos_nxt >= POS_W'(TAIL_RELEASED));
          end
        end
      end
    end
  end

  assign rx_word = rxsh_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_waddr,
  input  logic [BUS_W-1:0]     reg_wdata,
  input  logic [REG_IDX_W-1:0] reg_raddr,
  output logic [BUS_W-1:0]     reg_rdata,
  input  logic                 eng_done,
  input  logic [DATA_BITS-1:0] eng_rx,
  output logic [DIV_W-2:0]     half,
  output mdio_req_t            req,
  output logic                 start,
  output logic                 busy,
  output logic                 invalid
);
  localparam int MODE_W = DIV_W + 1;
  localparam int RGA_LO = 8;

  logic [MODE_W-1:0]     mode_q;
  logic [2:0]            cmd_q;
  logic [FIELD_BITS-1:0] phy_q;
  logic [FIELD_BITS-1:0] rga_q;
  logic [DATA_BITS-1:0]  wd_q;
  logic [DATA_BITS-1:0]  rx_q;
  logic                  linkfail_q;
  logic                  armed_q;
  logic                  scan_q;
  logic                  rdop_q;
  logic [BUS_W-1:0]      rd_mux;

  // host writes
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cmd_q  <= '0;
      phy_q  <= '0;
      rga_q  <= '0;
      wd_q   <= '0;
    end else if (reg_we) begin
      unique case (reg_waddr)
        RI_MODE: mode_q <= reg_wdata[MODE_W-1:0];
        RI_CMD:  cmd_q  <= reg_wdata[2:0];
        RI_ADDR: begin
          phy_q <= reg_wdata[FIELD_BITS-1:0];
          rga_q <= reg_wdata[RGA_LO+FIELD_BITS-1:RGA_LO];
        end
        RI_WDAT: wd_q <= reg_wdata[DATA_BITS-1:0];
        default: ;
      endcase
    end
  end

  // command sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      invalid    <= 1'b0;
      linkfail_q <= 1'b0;
      armed_q    <= 1'b1;
      scan_q     <= 1'b0;
      rdop_q     <= 1'b0;
      start      <= 1'b0;
      rx_q       <= '0;
    end else begin
      start <= 1'b0;
      if (!busy) begin
        if (armed_q && (cmd_q != '0)) begin
          busy    <= 1'b1;
          armed_q <= 1'b0;
          start   <= 1'b1;
          scan_q  <= cmd_q[CB_SCAN];
          rdop_q  <= cmd_q[CB_SCAN] | cmd_q[CB_READ];
          invalid <= cmd_q[CB_SCAN];
        end else if (cmd_q == '0) begin
          armed_q <= 1'b1;
        end
      end else if (eng_done) begin
        if (rdop_q) rx_q <= eng_rx;
        if (scan_q) begin
          linkfail_q <= ~eng_rx[2];
          invalid    <= 1'b0;
        end
        if (scan_q && cmd_q[CB_SCAN]) start <= 1'b1;
        else                          busy  <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_raddr)
      RI_MODE: rd_mux = BUS_W'(mode_q);
      RI_CMD:  rd_mux = BUS_W'(cmd_q);
      RI_ADDR: rd_mux = BUS_W'({rga_q, {(RGA_LO-FIELD_BITS){1'b0}}, phy_q});
      RI_WDAT: rd_mux = BUS_W'(wd_q);
      RI_RDAT: rd_mux = BUS_W'(rx_q);
      RI_STAT: rd_mux = BUS_W'({invalid, busy, linkfail_q});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign half      = mode_q[DIV_W-1:1];
  assign req.rd    = rdop_q;
  assign req.nopre = mode_q[DIV_W];
  assign req.phy   = phy_q;
  assign req.rga   = rga_q;
  assign req.wd    = wd_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_IDX_W-1:0] reg_waddr,
  input  logic [BUS_W-1:0]     reg_wdata,
  input  logic [REG_IDX_W-1:0] reg_raddr,
  output logic [BUS_W-1:0]     reg_rdata,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i
);
  logic                 eng_active;
  logic                 eng_start;
  logic                 eng_done;
  logic [DATA_BITS-1:0] eng_rx;
  logic [DIV_W-2:0]     half;
  mdio_req_t            req;
  logic                 busy;
  logic                 invalid;
  logic                 rise_now;
  logic                 fall_now;

  mdio_regs #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .eng_done(eng_done), .eng_rx(eng_rx),
    .half(half), .req(req), .start(eng_start),
    .busy(busy), .invalid(invalid)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(eng_active), .half(half),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now)
  );

  mdio_engine u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .req(req),
    .rise_now(rise_now), .fall_now(fall_now), .mdio_i(mdio_i),
    .active(eng_active), .done(eng_done), .rx_word(eng_rx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic eng_active,
  input logic start,
  input logic busy,
  input logic invalid
);
  p_line_stable_at_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_mdc_low_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !eng_active |=> !mdc);

  p_busy_covers_frame_r6: assert property (@(posedge clk) disable iff (rst)
    eng_active |-> busy);

  p_drive_only_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> eng_active);

  p_start_only_idle_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !eng_active);

  p_invalid_inside_busy_r9: assert property (@(posedge clk) disable iff (rst)
    invalid |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .eng_active(eng_active), .start(eng_start), .busy(busy), .invalid(invalid)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                         A_WDAT = 3'd3, A_RDAT = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_master dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // PHY model
  int          frames_done = 0, rise_cnt = 0, exp_len = 64, pre_off = 32;
  logic [63:0] cap_o = '0, cap_oe = '0, last_o = '0, last_oe = '0;
  logic [15:0] phy_data = '0;
  int          last_high = 0, last_low = 0;
  time         t_rise = 0, t_fall = 0;

  always @(posedge mdc) begin
    if (rise_cnt > 0) last_low = int'(($time - t_fall) / CLK_PERIOD);
    t_rise = $time;
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rise_cnt++;
  end

  always @(negedge mdc) begin
    int idx;
    last_high = int'(($time - t_rise) / CLK_PERIOD);
    t_fall = $time;
    if (rise_cnt >= exp_len) begin
      last_o  = cap_o;
      last_oe = cap_oe;
      frames_done++;
      rise_cnt = 0;
    end
    idx = rise_cnt - pre_off;
    mdio_i = (idx >= 16 && idx < 32) ? phy_data[31-idx] : 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic int exp_half(input logic [8:0] m);
    return (m[7:1] == 0) ? 1 : int'(m[7:1]);
  endfunction

  function automatic logic [31:0] exp_body(input bit rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [63:0] len_mask(input bit nopre);
    return nopre ? 64'h0000_0000_FFFF_FFFF : {64{1'b1}};
  endfunction

  function automatic logic [63:0] oe_mask(input bit rd, input bit nopre);
    return rd ? (len_mask(nopre) & ~64'h3FFFF) : len_mask(nopre);
  endfunction

  task automatic check_frame(input string tag, input bit rd, input bit nopre,
                             input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [63:0] full, m;
    full = nopre ? {32'h0, exp_body(rd, p, r, d)} : {32'hFFFF_FFFF, exp_body(rd, p, r, d)};
    m = oe_mask(rd, nopre);
    chk({tag, " frame bits at rising mdc R10"}, last_o & m, full & m);
    chk({tag, " output enable pattern"}, last_oe & len_mask(nopre), m);
  endtask

  task automatic run_txn(input string tag, input logic [2:0] cmd, input logic [8:0] mode,
                         input logic [4:0] p, input logic [4:0] r, input logic [15:0] wd,
                         input logic [15:0] pd, input bit keep_cmd);
    logic [31:0] s, v;
    bit rd;
    int fd0;
    rd = cmd[1];
    write_reg(A_MODE, {23'h0, mode});
    write_reg(A_ADDR, {19'h0, r, 3'b000, p});
    write_reg(A_WDAT, {16'h5A5A, wd});
    phy_data = pd;
    exp_len  = mode[8] ? 32 : 64;
    pre_off  = mode[8] ? 0 : 32;
    rise_cnt = 0;
    fd0 = frames_done;
    write_reg(A_CMD, {29'h0, cmd});
    @(negedge clk);
    read_reg(A_STAT, s);
    chk("R6 busy high after command", 64'(s[1]), 64'd1);
    for (int i = 0; i < 4000 && s[1]; i++) read_reg(A_STAT, s);
    chk("R6 busy drops after frame", 64'(s[1]), 64'd0);
    chk("R6 exactly one frame", 64'(frames_done), 64'(fd0 + 1));
    check_frame(tag, rd, mode[8], p, r, wd);
    chk("R2 mdc high width", 64'(last_high), 64'(exp_half(mode)));
    chk("R2 mdc low width", 64'(last_low), 64'(exp_half(mode)));
    if (rd) begin
      read_reg(A_RDAT, v);
      chk({tag, " read data R4"}, 64'(v), 64'(pd));
    end
    if (!keep_cmd) write_reg(A_CMD, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s;
    int fd0, fd;
    int unsigned seed_v;
    seed_v = $urandom(32'd24601);
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);
    chk("R1 mdio_o low", 64'(mdio_o), 64'd0);
    read_reg(A_STAT, v); chk("R1 status zero", 64'(v), 64'd0);
    read_reg(A_RDAT, v); chk("R1 read data zero", 64'(v), 64'd0);
    read_reg(A_MODE, v); chk("R1 mode zero", 64'(v), 64'd0);
    read_reg(A_CMD, v);  chk("R1 command zero", 64'(v), 64'd0);

    // directed frames
    run_txn("R3 write", 3'b100, 9'h004, 5'h11, 5'h0A, 16'hC3A5, 16'h0000, 0);
    run_txn("R4 read", 3'b010, 9'h006, 5'h1F, 5'h01, 16'h0000, 16'h8001, 0);
    run_txn("R2 odd divider read", 3'b010, 9'h007, 5'h02, 5'h1E, 16'h0, 16'h7FFE, 0);
    run_txn("R5 no preamble write", 3'b100, 9'h100, 5'h00, 5'h1F, 16'h0F0F, 16'h0, 0);
    run_txn("R5 no preamble read", 3'b010, 9'h101, 5'h15, 5'h0A, 16'h0, 16'h5A3C, 0);
    run_txn("R8 read over write", 3'b110, 9'h002, 5'h05, 5'h06, 16'hFFFF, 16'h1357, 0);

    // R7 held command does not repeat
    run_txn("R7 held write", 3'b100, 9'h102, 5'h07, 5'h08, 16'hBEEF, 16'h0, 1);
    fd = frames_done;
    repeat (40) @(negedge clk);
    chk("R7 no relaunch while command held", 64'(frames_done), 64'(fd));
    read_reg(A_STAT, s);
    chk("R7 busy stays low while command held", 64'(s[1]), 64'd0);
    write_reg(A_CMD, 32'h0);
    run_txn("R7 rearmed read", 3'b010, 9'h102, 5'h09, 5'h03, 16'h0, 16'hA0A0, 0);

    // constrained random mix
    for (int k = 0; k < 10; k++) begin
      logic [8:0] m;
      bit rd;
      m  = {1'($urandom % 2), 8'($urandom % 10)};
      rd = 1'($urandom % 2);
      run_txn(rd ? "R4 random read" : "R3 random write", rd ? 3'b010 : 3'b100, m,
              5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 0);
    end

    // R9 scan with all command bits set
    write_reg(A_MODE, 32'h102);
    write_reg(A_ADDR, {19'h0, 5'h01, 3'b000, 5'h03});
    phy_data = 16'h1230;
    exp_len = 32; pre_off = 0; rise_cnt = 0;
    fd0 = frames_done;
    write_reg(A_CMD, 32'h7);
    @(negedge clk);
    read_reg(A_STAT, s);
    chk("R9 invalid and busy at scan start", 64'(s[2:0]), 64'h6);
    for (int i = 0; i < 2000 && frames_done < fd0 + 1; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    read_reg(A_STAT, s);
    chk("R9 link fail after first scan read", 64'(s[2:0]), 64'h3);
    read_reg(A_RDAT, v);
    chk("R9 scan read data", 64'(v), 64'h1230);
    check_frame("R9 scan beats read/write", 1, 1, 5'h03, 5'h01, 16'h0);
    phy_data = 16'hABC4;
    for (int i = 0; i < 2000 && frames_done < fd0 + 3; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    read_reg(A_STAT, s);
    chk("R9 link good on later scan read", 64'(s[2:0]), 64'h2);
    read_reg(A_RDAT, v);
    chk("R9 scan data refreshed", 64'(v), 64'hABC4);
    write_reg(A_CMD, 32'h0);
    read_reg(A_STAT, s);
    for (int i = 0; i < 2000 && s[1]; i++) read_reg(A_STAT, s);
    chk("R9 scan stopped", 64'(s[2:0]), 64'h0);
    fd = frames_done;
    repeat (40) @(negedge clk);
    chk("R9 no frames after scan cleared", 64'(frames_done), 64'(fd));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule